// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block decides which of two programmed 3-bit charge-pump current codes drives the charge pump. While the loop is settling after a new frequency has been programmed, a higher "settling" current code is used. Once the loop has settled, the lower "steady" current code is used. Fastlock begins when software writes a gain bit of 1 into the divider latch. The write reaches this block as a strobe with one data bit.

A mode bit selects how fastlock ends. In manual mode, fastlock ends only when software writes the gain bit back to 0. In timed mode, a timer counts phase-detector cycles and ends fastlock after 3 + 4×TC cycles, where TC is a 4-bit code. When the timer expires, the hardware clears the stored gain bit itself, so the bit is ready for the next frequency change. A halt input stands for power-down or counter reset. It clears the timer and the gain bit, and it drops fastlock at once.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: After reset, `gain_bit` and `fl_active` are 0 and `cp_code` equals `cur_steady`.
- R2: `cp_code` equals `cur_settle` whenever `fl_active` is 1, and equals `cur_steady` otherwise. The selection follows the inputs in the same cycle.
- R3: A `gain_wr` pulse stores `gain_wdata` into `gain_bit` at the next clock edge. `fl_active` is `fl_en` AND `gain_bit` AND NOT `halt`.
- R4: In manual mode (`fl_mode` = 0), `fl_active` stays 1 through any number of `pfd_tick` pulses until a write of 0 arrives.
- R5: In timed mode (`fl_mode` = 1, `fl_en` = 1), a write of 1 arms a timeout of 3 + 4×`tmo_code` ticks. Fastlock stays active through the first (timeout − 1) ticks and ends at the clock edge that takes the last tick. With code 0 the timeout is 3 ticks; with code 15 it is 63 ticks.
- R6: When the timeout expires, `gain_bit` reads 0 from the following cycle onward.
- R7: The timer runs only while `fl_en` = 1 and `fl_mode` = 1. Leaving timed mode discards any timeout in progress, but the stored gain bit is kept.
- R8: A new write of 1 during a timeout in progress restarts the full timeout.
- R9: `halt` = 1 forces `fl_active` to 0 in the same cycle. It clears `gain_bit` and the timer at the next edge. `halt` takes priority over a write, and a write takes priority over expiry.
- R10: With `fl_en` = 0, writes still update `gain_bit`, but `cp_code` always equals `cur_steady`.
- R11: In timed mode, a write of 0 ends fastlock at the next edge, and later ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_en | input | 1 | Fastlock enable |
| fl_mode | input | 1 | 0 = manual end, 1 = timed end |
| tmo_code | input | 4 | Timeout code TC; timeout is 3 + 4×TC ticks |
| cur_steady | input | 3 | Current code used outside fastlock |
| cur_settle | input | 3 | Current code used during fastlock |
| gain_wr | input | 1 | Divider-latch write strobe |
| gain_wdata | input | 1 | Gain bit carried by the write |
| pfd_tick | input | 1 | One phase-detector cycle has elapsed |
| halt | input | 1 | Power-down or counter reset |
| cp_code | output | 3 | Active charge-pump current code |
| fl_active | output | 1 | Fastlock in effect |
| gain_bit | output | 1 | Stored gain bit |

## Verification
Writes, ticks and expiry show up one clock edge after the input is applied. `cp_code` and `fl_active` also respond to `fl_en` and `halt` in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge. A sample therefore always sees exactly one rising edge plus the current combinational response. The timeout checks count ticks one per cycle: they sample after (timeout − 1) ticks and again after the last tick, so an off-by-one error is caught on either side.

// File: rtl/fl_pkg.sv
// Shared constants and helpers for the fastlock current controller.
// Assumes the timeout law base + (code << step) fits in TC_W+2 bits.
package fl_pkg;
    localparam int FL_CODE_W  = 3;
    localparam int FL_TC_W    = 4;
    localparam int FL_TMO_BASE = 3;
    localparam int FL_TMO_SH   = 2;
endpackage

// File: rtl/fl_tmo_timer.sv
// Timeout timer for timed fastlock. It counts phase-detector ticks down from
// 3 + 4*code and raises expire for one cycle, on the tick that ends the window.
// Assumes load and clear come from single-cycle write strobes.
module fl_tmo_timer #(
    parameter int TC_W = fl_pkg::FL_TC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic            load,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            expire
);
    localparam int CNT_W = TC_W + fl_pkg::FL_TMO_SH;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    // Timeout length derived from the code.
    always_comb begin
        len = CNT_W'(fl_pkg::FL_TMO_BASE) + (CNT_W'(tc) << fl_pkg::FL_TMO_SH);
    end

    // Down-counter: cleared outside timed mode, reloaded by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry pulse on the tick that consumes the final count.
    always_comb begin
        expire = run && !clear && !load && tick && (cnt_q == CNT_W'(1));
    end

    assert_tmo_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    assert_tmo_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load && !clear) |=> (cnt_q == $past(len)));
    assert_tmo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/fl_gain_reg.sv
// Holds the gain bit written through the divider latch. Priority is
// halt over write over timer expiry. Assumes the write is a one-cycle strobe.
module fl_gain_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic wr,
    input  logic wdata,
    input  logic expire,
    output logic gain_q
);
    // Gain bit register with the stated priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= 1'b0;
        end else if (halt) begin
            gain_q <= 1'b0;
        end else if (wr) begin
            gain_q <= wdata;
        end else if (expire) begin
            gain_q <= 1'b0;
        end
    end

    assert_gain_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !halt) |=> (gain_q == $past(wdata)));
    assert_gain_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !gain_q);
endmodule

// File: rtl/fl_cur_sel.sv
// Chooses the active current code. Fastlock is in effect only with the
// enable set, the gain bit stored and no halt. Purely combinational.
module fl_cur_sel #(
    parameter int CODE_W = fl_pkg::FL_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              gain,
    input  logic              halt,
    input  logic [CODE_W-1:0] lo,
    input  logic [CODE_W-1:0] hi,
    output logic              active,
    output logic [CODE_W-1:0] code
);
    // Fastlock qualification and code multiplexer.
    always_comb begin
        active = en && gain && !halt;
        code   = active ? hi : lo;
    end

    assert_sel_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (code == lo));
    assert_sel_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (code == lo));
endmodule

// File: rtl/fastlock_cp_ctrl.sv
// Top of the fastlock charge-pump current controller. It ties together the
// gain register, the timeout timer and the code selector. Assumes gain_wr is
// a single-cycle strobe and pfd_tick is synchronous to clk.
module fastlock_cp_ctrl #(
    parameter int CODE_W = fl_pkg::FL_CODE_W,
    parameter int TC_W   = fl_pkg::FL_TC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_en,
    input  logic              fl_mode,
    input  logic [TC_W-1:0]   tmo_code,
    input  logic [CODE_W-1:0] cur_steady,
    input  logic [CODE_W-1:0] cur_settle,
    input  logic              gain_wr,
    input  logic              gain_wdata,
    input  logic              pfd_tick,
    input  logic              halt,
    output logic [CODE_W-1:0] cp_code,
    output logic              fl_active,
    output logic              gain_bit
);
    logic tmr_run;
    logic tmr_clear;
    logic tmr_load;
    logic tmr_expire;

    // Timer control derived from the mode and the write strobe.
    always_comb begin
        tmr_run   = fl_en && fl_mode;
        tmr_clear = halt || (gain_wr && !gain_wdata);
        tmr_load  = gain_wr && gain_wdata;
    end

    fl_tmo_timer #(.TC_W(TC_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clear  (tmr_clear),
        .load   (tmr_load),
        .tick   (pfd_tick),
        .tc     (tmo_code),
        .expire (tmr_expire)
    );

    fl_gain_reg gain_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt   (halt),
        .wr     (gain_wr),
        .wdata  (gain_wdata),
        .expire (tmr_expire),
        .gain_q (gain_bit)
    );

    fl_cur_sel #(.CODE_W(CODE_W)) sel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fl_en),
        .gain   (gain_bit),
        .halt   (halt),
        .lo     (cur_steady),
        .hi     (cur_settle),
        .active (fl_active),
        .code   (cp_code)
    );

    assert_expire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire && !halt && !gain_wr) |=> !gain_bit);
    assert_manual_no_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_mode |-> !tmr_expire);
endmodule

// File: tb/fastlock_cp_ctrl_tb_top.sv
module fastlock_cp_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fl_en = 1'b0, fl_mode = 1'b0;
    logic [3:0] tmo_code = '0;
    logic [2:0] cur_steady = 3'd2, cur_settle = 3'd6;
    logic       gain_wr = 1'b0, gain_wdata = 1'b0, pfd_tick = 1'b0, halt = 1'b0;
    logic [2:0] cp_code;
    logic       fl_active, gain_bit;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state, updated from the requirements.
    logic       m_g = 1'b0;
    logic [5:0] m_c = '0;

    always #5 clk = ~clk;

    fastlock_cp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fl_en(fl_en), .fl_mode(fl_mode),
        .tmo_code(tmo_code), .cur_steady(cur_steady), .cur_settle(cur_settle),
        .gain_wr(gain_wr), .gain_wdata(gain_wdata), .pfd_tick(pfd_tick),
        .halt(halt), .cp_code(cp_code), .fl_active(fl_active), .gain_bit(gain_bit)
    );

    function automatic logic [5:0] tmo_len(input logic [3:0] tc);
        return 6'd3 + {tc, 2'b00};
    endfunction

    function automatic logic exp_active(input logic g);
        return fl_en && g && !halt;
    endfunction

    function automatic logic [2:0] exp_code(input logic g);
        return exp_active(g) ? cur_settle : cur_steady;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || halt) begin
            m_g <= 1'b0; m_c <= '0;
        end else if (gain_wr) begin
            m_g <= gain_wdata;
            m_c <= (gain_wdata && fl_en && fl_mode) ? tmo_len(tmo_code) : 6'd0;
        end else if (!(fl_en && fl_mode)) begin
            m_c <= '0;
        end else if (pfd_tick && m_c != 0) begin
            m_c <= m_c - 1'b1;
            if (m_c == 6'd1) m_g <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic wr, input logic wd, input logic tk, input logic hl);
        gain_wr = wr; gain_wdata = wd; pfd_tick = tk; halt = hl;
        @(negedge clk);
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " gain"}, gain_bit, m_g);
        chk({tag, " active"}, fl_active, exp_active(m_g));
        chk({tag, " code"}, cp_code, exp_code(m_g));
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 gain", gain_bit, 0);
        chk("R1 active", fl_active, 0);
        chk("R1 code", cp_code, 2);
        rst_n = 1'b1;
        fl_en = 1'b1; fl_mode = 1'b1; tmo_code = 4'd0;

        // R5: shortest timeout, 3 ticks
        cyc(1, 1, 0, 0);
        chk("R3 gain set", gain_bit, 1);
        chk("R2 settle code", cp_code, 6);
        cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
        chk("R5 active before last tick", fl_active, 1);
        cyc(0, 0, 1, 0);
        chk("R5 ended on tick 3", fl_active, 0);
        chk("R6 gain cleared", gain_bit, 0);
        chk("R2 steady code", cp_code, 2);

        // R5: longest timeout, 63 ticks, with idle cycles in between
        tmo_code = 4'd15;
        cyc(1, 1, 0, 0);
        for (int i = 0; i < 62; i++) begin
            cyc(0, 0, 1, 0);
            cyc(0, 0, 0, 0);
        end
        chk("R5 active after 62 ticks", fl_active, 1);
        cyc(0, 0, 1, 0);
        chk("R5 ended on tick 63", fl_active, 0);

        // R8: rewrite restarts the window
        tmo_code = 4'd1; // 7 ticks
        cyc(1, 1, 0, 0);
        repeat (5) cyc(0, 0, 1, 0);
        cyc(1, 1, 0, 0);
        repeat (6) cyc(0, 0, 1, 0);
        chk("R8 still active after reload", fl_active, 1);
        cyc(0, 0, 1, 0);
        chk("R8 ends 7 ticks after reload", fl_active, 0);

        // R11: write 0 in timed mode
        cyc(1, 1, 0, 0);
        cyc(1, 0, 0, 0);
        chk("R11 ended by write 0", fl_active, 0);
        repeat (10) cyc(0, 0, 1, 0);
        chk("R11 gain stays 0", gain_bit, 0);

        // R4: manual mode ignores ticks
        fl_mode = 1'b0;
        cyc(1, 1, 0, 0);
        repeat (100) cyc(0, 0, 1, 0);
        chk("R4 manual still active", fl_active, 1);
        cyc(1, 0, 0, 0);
        chk("R4 manual ended by write", fl_active, 0);

        // R7: leaving timed mode discards the timeout, keeps gain
        fl_mode = 1'b1; tmo_code = 4'd0;
        cyc(1, 1, 0, 0);
        fl_mode = 1'b0;
        cyc(0, 0, 1, 0);
        fl_mode = 1'b1;
        repeat (10) cyc(0, 0, 1, 0);
        chk("R7 gain kept without timer", gain_bit, 1);

        // R9: halt, same cycle and next
        cyc(0, 0, 0, 1);
        chk("R9 halt clears gain", gain_bit, 0);
        gain_wr = 1'b1; gain_wdata = 1'b1; halt = 1'b0;
        @(negedge clk);
        gain_wr = 1'b0; halt = 1'b1;
        #1;
        chk("R9 halt forces inactive now", fl_active, 0);
        chk("R9 halt code steady", cp_code, 2);
        cyc(1, 1, 0, 1);
        chk("R9 halt beats write", gain_bit, 0);
        cyc(0, 0, 0, 0);

        // R10: enable off stores gain, uses steady code
        fl_en = 1'b0;
        cyc(1, 1, 0, 0);
        chk("R10 gain stored", gain_bit, 1);
        chk("R10 code steady", cp_code, 2);
        chk("R10 inactive", fl_active, 0);
        cyc(1, 0, 0, 0);

        // Random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            fl_en = ($urandom % 8) != 0;
            if ($urandom % 20 == 0) fl_mode = $urandom;
            if ($urandom % 30 == 0) tmo_code = $urandom;
            cur_steady = $urandom; cur_settle = $urandom;
            cyc(($urandom % 6) == 0, $urandom, ($urandom % 2) == 0, ($urandom % 50) == 0);
            chk_model("R2 R3 R5 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule